// File: doc/BRIEF.md
# AAL1 Receive Sequence Number Processor

This block sits on the receive side of a circuit-emulation reassembly path and inspects the one-byte adaptation header that leads every cell of a single queue. It repairs the header where the protection code allows, tracks the 3-bit sequence count, and issues one decision for each cell. The decision says whether the cell payload is written to the playout buffer and how many filler cells go in ahead of it, so that a lost cell or a single damaged cell does not shift the reconstructed bit stream.

Two tracking algorithms are offered. The fast one acts on each cell as it arrives. The robust one holds back judgement on an out-of-sequence cell until the next cell shows whether cells were lost or one was misinserted. The robust algorithm is only permitted on unstructured connections. The filler content (fixed byte, pseudo-random, or repeat of previous data) is chosen by configuration and travels with each decision to the payload writer. Six wrapping event counters record what the block saw.

Top module: `aal1_rx_sn`

## Requirements
- R1: The header byte is laid out as bit 7 = CSI, bits 6:4 = sequence count, bits 3:1 = CRC-3 of bits 7:4 with generator x^3+x+1 (bit 3 the highest remainder term), bit 0 = even parity over the whole byte; a header that satisfies both checks is valid and is taken unchanged.
- R2: A header with a single flipped bit (any of the eight, including the parity bit) is corrected and treated as valid with the repaired count; every header that fails either check increments `cnt_hdrerr`.
- R3: A header with a detectable multi-bit error (nonzero CRC syndrome with correct parity) is invalid; in the locked state that cell is dropped, and if the next header is valid and carries the count one past the errored cell, that cell is accepted with a fill count of 1.
- R4: After reset, resynchronisation or sequence-off operation no cell is accepted until two consecutive valid headers with consecutive counts arrive; the first is dropped, the second accepted with fill 0, and an out-of-sequence valid header while waiting restarts the pair from itself.
- R5: In the fast algorithm a valid locked-state header whose count is ahead of the expected one by d = 1..6 (modulo 8) is accepted with fill count d; `cnt_lost` grows by d and `cnt_badsn` by 1.
- R6: In either algorithm a valid locked-state header one count behind the expected one (difference 7) is dropped as misinserted, the expected count is kept, and `cnt_misins` and `cnt_badsn` each grow by 1.
- R7: In the robust algorithm a locked-state header ahead by d = 1..6 is dropped and remembered; if the next header carries the remembered count plus one it is accepted with fill d+1 and `cnt_lost` grows by d, if it carries the original expected count it is accepted with fill 0 and `cnt_misins` grows by 1, otherwise the block drops it and resynchronises.
- R8: The robust algorithm is in force only when `cfg_robust` is 1 and `cfg_structured` is 0; otherwise the fast algorithm applies.
- R9: With `cfg_sn_off` = 1 every cell is accepted with fill 0 whatever its header, this setting wins over `cfg_robust`, and sequence tracking restarts from the waiting state afterwards.
- R10: A cell arriving while `underrun` is 1 (and sequence checking is on) is dropped and leaves the sequence state unchanged.
- R11: `dec_vld` is 1 in exactly the cycle after a cycle with `hdr_vld` = 1; with it, `dec_acc`, `dec_fill` and `dec_fmode` (the value of `cfg_fill_mode` in the header cycle: 0 fixed byte, 1 pseudo-random, 2 repeat previous) are valid, and `dec_fill` is 0 when `dec_acc` is 0.
- R12: `cnt_total` counts every header and `cnt_drop` every cell with `dec_acc` = 0; counters change in the same cycle as the decision and wrap at their width.
- R13: Reset clears all counters and `dec_vld` and puts tracking in the waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_vld | input | 1 | Header byte present this cycle |
| hdr_byte | input | 8 | Received adaptation header |
| underrun | input | 1 | Queue is in underrun |
| cfg_sn_off | input | 1 | Sequence checking disabled |
| cfg_robust | input | 1 | Request robust algorithm |
| cfg_structured | input | 1 | Connection carries structured data |
| cfg_fill_mode | input | 2 | Filler content selection |
| dec_vld | output | 1 | Decision valid |
| dec_acc | output | 1 | Accept cell payload |
| dec_fill | output | 3 | Filler cells to insert before the cell |
| dec_fmode | output | 2 | Filler content for this decision |
| cnt_total | output | CW | Headers received |
| cnt_drop | output | CW | Cells dropped |
| cnt_badsn | output | CW | Unexpected sequence counts |
| cnt_hdrerr | output | CW | Headers failing CRC or parity |
| cnt_lost | output | CW | Cells judged lost |
| cnt_misins | output | CW | Cells judged misinserted |

## Verification
The embedded properties assume that a header arrives as a single-cycle `hdr_vld` pulse, that configuration and `underrun` are steady while the pulse is high, and that filler counts above six never need to be expressed. The stimulus drives each header for one cycle followed by an idle cycle, changes configuration only between cells, and builds every header from a count and a chosen corruption pattern (none, one data bit, two data bits, parity bit), so the sequence gaps it produces stay within the 1..7 range the requirements define.

// File: rtl/aal1_sn_pkg.sv
package aal1_sn_pkg;

  localparam int SCW = 3;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_SYNC1 = 3'd1,
    ST_LOCK  = 3'd2,
    ST_PEND  = 3'd3,
    ST_ERR   = 3'd4
  } sn_state_e;

  typedef struct packed {
    logic           ok;   // header usable (clean or corrected)
    logic           err;  // header failed a check
    logic           csi;
    logic [SCW-1:0] sc;
  } hdr_info_t;

  // counter slots
  localparam int C_TOTAL  = 0;
  localparam int C_DROP   = 1;
  localparam int C_BADSN  = 2;
  localparam int C_HDRERR = 3;
  localparam int C_LOST   = 4;
  localparam int C_MISINS = 5;
  localparam int NCNT     = 6;

  // CRC-3, generator x^3+x+1, over 4 data bits (MSB first)
  function automatic logic [2:0] crc3(input logic [3:0] d);
    logic [2:0] r;
    logic       fb;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      fb = d[i] ^ r[2];
      r  = {r[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return r;
  endfunction

  function automatic hdr_info_t hdr_decode(input logic [7:0] b);
    hdr_info_t  r;
    logic [3:0] d;
    logic [2:0] syn;
    logic       par_bad;
    d       = b[7:4];
    syn     = crc3(d) ^ b[3:1];
    par_bad = ^b;
    r.ok    = 1'b1;
    r.err   = 1'b0;
    if (par_bad) begin
      r.err = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (syn != 3'b000 && syn == crc3(4'(1 << i))) d[i] = ~d[i];
      end
    end else if (syn != 3'b000) begin
      r.err = 1'b1;
      r.ok  = 1'b0;
    end
    r.csi = d[3];
    r.sc  = d[2:0];
    return r;
  endfunction

  // modulo-8 distance from expected to received
  function automatic logic [SCW-1:0] sc_diff(input logic [SCW-1:0] got,
                                             input logic [SCW-1:0] want);
    return got - want;
  endfunction

endpackage

// File: rtl/aal1_hdr_decode.sv
module aal1_hdr_decode
  import aal1_sn_pkg::*;
(
  input  logic [7:0] hdr_byte,
  output hdr_info_t  info
);
  assign info = hdr_decode(hdr_byte);
endmodule

// File: rtl/aal1_sn_fsm.sv
module aal1_sn_fsm
  import aal1_sn_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hdr_vld,
  input  hdr_info_t      info,
  input  logic           underrun,
  input  logic           sn_off,
  input  logic           robust_eff,
  input  logic [1:0]     fill_mode,
  output logic           dec_vld,
  output logic           dec_acc,
  output logic [2:0]     dec_fill,
  output logic [1:0]     dec_fmode,
  // event wires for counters and checks
  output logic           ev_drop,
  output logic           ev_badsn,
  output logic           ev_misins,
  output logic [2:0]     ev_lost,
  output sn_state_e      st_o
);

  sn_state_e      st_q, st_n;
  logic [SCW-1:0] exp_q, exp_n, cand_q, cand_n;
  logic [SCW-1:0] diff, cand_gap;
  logic           acc;
  logic [2:0]     fill;

  assign diff     = sc_diff(info.sc, exp_q);
  assign cand_gap = sc_diff(cand_q, exp_q);

  always_comb begin
    st_n      = st_q;
    exp_n     = exp_q;
    cand_n    = cand_q;
    acc       = 1'b0;
    fill      = 3'd0;
    ev_badsn  = 1'b0;
    ev_misins = 1'b0;
    ev_lost   = 3'd0;
    if (hdr_vld) begin
      if (sn_off) begin
        acc  = 1'b1;
        st_n = ST_HUNT;
      end else if (!underrun) begin
        unique case (st_q)
          ST_HUNT: begin
            if (info.ok) begin
              st_n  = ST_SYNC1;
              exp_n = info.sc + 3'd1;
            end
          end
          ST_SYNC1: begin
            if (!info.ok) st_n = ST_HUNT;
            else begin
              exp_n = info.sc + 3'd1;
              if (diff == 3'd0) begin
                st_n = ST_LOCK;
                acc  = 1'b1;
              end
            end
          end
          ST_LOCK: begin
            if (!info.ok) begin
              st_n  = ST_ERR;
              exp_n = exp_q + 3'd1;
            end else if (diff == 3'd0) begin
              acc   = 1'b1;
              exp_n = exp_q + 3'd1;
            end else begin
              ev_badsn = 1'b1;
              if (diff == 3'd7) ev_misins = 1'b1;
              else if (robust_eff) begin
                st_n   = ST_PEND;
                cand_n = info.sc;
              end else begin
                acc     = 1'b1;
                fill    = diff;
                ev_lost = diff;
                exp_n   = info.sc + 3'd1;
              end
            end
          end
          ST_PEND: begin
            if (info.ok && info.sc == cand_q + 3'd1) begin
              acc     = 1'b1;
              fill    = cand_gap + 3'd1;
              ev_lost = cand_gap;
              exp_n   = info.sc + 3'd1;
              st_n    = ST_LOCK;
            end else if (info.ok && diff == 3'd0) begin
              acc       = 1'b1;
              ev_misins = 1'b1;
              exp_n     = exp_q + 3'd1;
              st_n      = ST_LOCK;
            end else begin
              ev_badsn = info.ok;
              st_n     = ST_HUNT;
            end
          end
          ST_ERR: begin
            if (info.ok && diff == 3'd0) begin
              acc   = 1'b1;
              fill  = 3'd1;
              exp_n = exp_q + 3'd1;
              st_n  = ST_LOCK;
            end else begin
              ev_badsn = info.ok;
              st_n     = ST_HUNT;
            end
          end
          default: st_n = ST_HUNT;
        endcase
      end
    end
  end

  assign ev_drop = hdr_vld & ~acc;
  assign st_o    = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      exp_q     <= '0;
      cand_q    <= '0;
      dec_vld   <= 1'b0;
      dec_acc   <= 1'b0;
      dec_fill  <= 3'd0;
      dec_fmode <= 2'd0;
    end else begin
      st_q    <= st_n;
      exp_q   <= exp_n;
      cand_q  <= cand_n;
      dec_vld <= hdr_vld;
      if (hdr_vld) begin
        dec_acc   <= acc;
        dec_fill  <= fill;
        dec_fmode <= fill_mode;
      end
    end
  end

  // R10: underrun freezes tracking
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && underrun && !sn_off |=> st_q == $past(st_q) && exp_q == $past(exp_q));

  // R11: one decision per header, one cycle later
  p_dec_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |=> dec_vld);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_vld |=> !dec_vld);
  p_fill_only_acc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld && !dec_acc |-> dec_fill == 3'd0);

  // R9: sequence-off accepts everything
  p_snoff_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && sn_off |=> dec_acc && dec_fill == 3'd0);

  // R4: nothing accepted while hunting
  p_hunt_no_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && !sn_off && st_q == ST_HUNT |=> !dec_acc);

  // R8: the pending state is entered only under the robust algorithm
  p_pend_robust_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && !sn_off && !underrun && st_q == ST_LOCK && !robust_eff |=> st_q != ST_PEND);

endmodule

// File: rtl/aal1_sn_counters.sv
module aal1_sn_counters #(
  parameter int CW = 16,
  parameter int N  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0][2:0]    inc,
  output logic [N-1:0][CW-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[g] <= '0;
      else        cnt[g] <= cnt[g] + CW'(inc[g]);
    end
  end
endmodule

// File: rtl/aal1_rx_sn.sv
module aal1_rx_sn
  import aal1_sn_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_vld,
  input  logic [7:0]    hdr_byte,
  input  logic          underrun,
  input  logic          cfg_sn_off,
  input  logic          cfg_robust,
  input  logic          cfg_structured,
  input  logic [1:0]    cfg_fill_mode,
  output logic          dec_vld,
  output logic          dec_acc,
  output logic [2:0]    dec_fill,
  output logic [1:0]    dec_fmode,
  output logic [CW-1:0] cnt_total,
  output logic [CW-1:0] cnt_drop,
  output logic [CW-1:0] cnt_badsn,
  output logic [CW-1:0] cnt_hdrerr,
  output logic [CW-1:0] cnt_lost,
  output logic [CW-1:0] cnt_misins
);

  hdr_info_t                 info;
  logic                      robust_eff;
  logic                      ev_drop, ev_badsn, ev_misins;
  logic [2:0]                ev_lost;
  sn_state_e                 st;
  logic [NCNT-1:0][2:0]      inc;
  logic [NCNT-1:0][CW-1:0]   cnt;

  assign robust_eff = cfg_robust & ~cfg_structured;

  aal1_hdr_decode u_dec (
    .hdr_byte (hdr_byte),
    .info     (info)
  );

  aal1_sn_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_vld    (hdr_vld),
    .info       (info),
    .underrun   (underrun),
    .sn_off     (cfg_sn_off),
    .robust_eff (robust_eff),
    .fill_mode  (cfg_fill_mode),
    .dec_vld    (dec_vld),
    .dec_acc    (dec_acc),
    .dec_fill   (dec_fill),
    .dec_fmode  (dec_fmode),
    .ev_drop    (ev_drop),
    .ev_badsn   (ev_badsn),
    .ev_misins  (ev_misins),
    .ev_lost    (ev_lost),
    .st_o       (st)
  );

  always_comb begin
    inc           = '0;
    inc[C_TOTAL]  = {2'b00, hdr_vld};
    inc[C_DROP]   = {2'b00, ev_drop};
    inc[C_BADSN]  = {2'b00, ev_badsn};
    inc[C_HDRERR] = {2'b00, hdr_vld & info.err};
    inc[C_LOST]   = ev_lost;
    inc[C_MISINS] = {2'b00, ev_misins};
  end

  aal1_sn_counters #(.CW(CW), .N(NCNT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc),
    .cnt   (cnt)
  );

  assign cnt_total  = cnt[C_TOTAL];
  assign cnt_drop   = cnt[C_DROP];
  assign cnt_badsn  = cnt[C_BADSN];
  assign cnt_hdrerr = cnt[C_HDRERR];
  assign cnt_lost   = cnt[C_LOST];
  assign cnt_misins = cnt[C_MISINS];

  // R12: every header bumps the total by one
  p_total_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |=> cnt_total == $past(cnt_total) + CW'(1));
  // R12: a drop decision is matched by the drop counter
  p_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |=> (cnt_drop == $past(cnt_drop) + CW'(1)) == !dec_acc);
  // R13: counters hold between headers
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_vld |=> $stable(cnt_total) && $stable(cnt_lost));

endmodule

// File: tb/aal1_rx_sn_bench.sv
`timescale 1ns/100ps
module aal1_rx_sn_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hdr_vld = 1'b0;
  logic [7:0]    hdr_byte = 8'h00;
  logic          underrun = 1'b0;
  logic          cfg_sn_off = 1'b0;
  logic          cfg_robust = 1'b0;
  logic          cfg_structured = 1'b0;
  logic [1:0]    cfg_fill_mode = 2'd0;
  logic          dec_vld, dec_acc;
  logic [2:0]    dec_fill;
  logic [1:0]    dec_fmode;
  logic [CW-1:0] cnt_total, cnt_drop, cnt_badsn, cnt_hdrerr, cnt_lost, cnt_misins;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  aal1_rx_sn #(.CW(CW)) u_aal1_rx_sn (
    .clk, .rst_n, .hdr_vld, .hdr_byte, .underrun, .cfg_sn_off, .cfg_robust,
    .cfg_structured, .cfg_fill_mode, .dec_vld, .dec_acc, .dec_fill, .dec_fmode,
    .cnt_total, .cnt_drop, .cnt_badsn, .cnt_hdrerr, .cnt_lost, .cnt_misins
  );

  // fields: [9] robust, [8:6] count, [5:4] damage, [3] accept, [2:0] fill
  // damage: 0 none, 1 flip bit 6, 2 flip bits 6 and 5, 3 flip parity bit
  localparam int NV = 24;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 3'd0, 2'd0, 1'b0, 3'd0},  // R4 first of pair dropped
    {1'b0, 3'd1, 2'd0, 1'b1, 3'd0},  // R4 second accepted
    {1'b0, 3'd2, 2'd0, 1'b1, 3'd0},  // R1
    {1'b0, 3'd5, 2'd0, 1'b1, 3'd2},  // R5 gap of 2
    {1'b0, 3'd6, 2'd0, 1'b1, 3'd0},
    {1'b0, 3'd7, 2'd1, 1'b1, 3'd0},  // R2 data bit corrected
    {1'b0, 3'd0, 2'd2, 1'b0, 3'd0},  // R3 invalid header
    {1'b0, 3'd1, 2'd0, 1'b1, 3'd1},  // R3 errored cell replaced
    {1'b0, 3'd2, 2'd3, 1'b1, 3'd0},  // R2 parity bit corrected
    {1'b0, 3'd1, 2'd0, 1'b1, 3'd6},  // R5 gap of 6
    {1'b0, 3'd1, 2'd0, 1'b0, 3'd0},  // R6 one behind
    {1'b0, 3'd2, 2'd0, 1'b1, 3'd0},  // R6 expected count kept
    {1'b1, 3'd6, 2'd0, 1'b0, 3'd0},  // R7 held
    {1'b1, 3'd7, 2'd0, 1'b1, 3'd4},  // R7 loss confirmed
    {1'b1, 3'd3, 2'd0, 1'b0, 3'd0},  // R7 held
    {1'b1, 3'd0, 2'd0, 1'b1, 3'd0},  // R7 misinsertion
    {1'b1, 3'd1, 2'd0, 1'b1, 3'd0},
    {1'b1, 3'd5, 2'd0, 1'b0, 3'd0},  // R7 held
    {1'b1, 3'd3, 2'd0, 1'b0, 3'd0},  // R7 neither, resync
    {1'b1, 3'd4, 2'd0, 1'b0, 3'd0},  // R4
    {1'b1, 3'd6, 2'd0, 1'b0, 3'd0},  // R4 pair restarts
    {1'b1, 3'd7, 2'd0, 1'b1, 3'd0},  // R4
    {1'b1, 3'd0, 2'd2, 1'b0, 3'd0},  // R3
    {1'b1, 3'd1, 2'd0, 1'b1, 3'd1}   // R3
  };

  // header built by polynomial long division
  function automatic logic [7:0] make_hdr(input logic csi, input logic [2:0] sc,
                                          input logic [1:0] dmg);
    logic [6:0] v;
    logic [3:0] d;
    logic [7:0] h;
    d = {csi, sc};
    v = {d, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b0001011 << (i - 3));
    h = {d, v[2:0], 1'b0};
    h[0] = ^h;
    case (dmg)
      2'd1:    h = h ^ 8'h40;
      2'd2:    h = h ^ 8'h60;
      2'd3:    h = h ^ 8'h01;
      default: h = h;
    endcase
    return h;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one header, return at the negedge after the decision edge
  task automatic send(input logic csi, input logic [2:0] sc, input logic [1:0] dmg);
    @(negedge clk);
    hdr_vld  = 1'b1;
    hdr_byte = make_hdr(csi, sc, dmg);
    @(negedge clk);
    hdr_vld  = 1'b0;
  endtask

  task automatic expect_dec(input bit acc, input logic [2:0] fill, input string tag);
    chk(dec_vld == 1'b1, {tag, " dec_vld"}, int'(dec_vld), 1);
    chk(dec_acc == acc, {tag, " accept"}, int'(dec_acc), int'(acc));
    chk(dec_fill == fill, {tag, " fill"}, int'(dec_fill), int'(fill));
  endtask

  task automatic check_zero(input string tag);
    chk(dec_vld == 1'b0, {tag, " dec_vld"}, int'(dec_vld), 0);
    chk(cnt_total == 0 && cnt_drop == 0 && cnt_badsn == 0 && cnt_hdrerr == 0 &&
        cnt_lost == 0 && cnt_misins == 0, {tag, " counters"},
        int'(cnt_total + cnt_drop + cnt_lost), 0);
  endtask

  initial begin
    int t0, d0;
    repeat (3) @(negedge clk);
    check_zero("R13 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_vld == 1'b0, "R11 idle", int'(dec_vld), 0);

    for (int i = 0; i < NV; i++) begin
      cfg_robust    = VEC[i][9];
      cfg_fill_mode = 2'(i % 3);
      send(1'b0, VEC[i][8:6], VEC[i][5:4]);
      expect_dec(VEC[i][3], VEC[i][2:0], $sformatf("vec%0d R1", i));
      chk(dec_fmode == 2'(i % 3), "R11 fmode", int'(dec_fmode), i % 3);
      @(negedge clk);
      chk(dec_vld == 1'b0, "R11 single pulse", int'(dec_vld), 0);
    end

    chk(cnt_total == 24,  "R12 total",  int'(cnt_total), 24);
    chk(cnt_drop == 10,   "R12 drop",   int'(cnt_drop), 10);
    chk(cnt_lost == 11,   "R5 lost",    int'(cnt_lost), 11);
    chk(cnt_misins == 2,  "R6 misins",  int'(cnt_misins), 2);
    chk(cnt_badsn == 7,   "R12 badsn",  int'(cnt_badsn), 7);
    chk(cnt_hdrerr == 4,  "R2 hdrerr",  int'(cnt_hdrerr), 4);

    // R10: underrun drops and freezes (expected count is 2)
    cfg_robust = 1'b0;
    t0 = int'(cnt_total); d0 = int'(cnt_drop);
    underrun = 1'b1;
    send(1'b1, 3'd5, 2'd0);
    expect_dec(1'b0, 3'd0, "R10 underrun drop");
    underrun = 1'b0;
    send(1'b1, 3'd2, 2'd0);
    expect_dec(1'b1, 3'd0, "R10 state frozen");
    chk(int'(cnt_total) == t0 + 2, "R12 total underrun", int'(cnt_total), t0 + 2);
    chk(int'(cnt_drop) == d0 + 1, "R12 drop underrun", int'(cnt_drop), d0 + 1);

    // R11: fill mode repeat-previous travels with the decision
    cfg_fill_mode = 2'd2;
    send(1'b1, 3'd3, 2'd0);
    expect_dec(1'b1, 3'd0, "R11 mode cell");
    chk(dec_fmode == 2'd2, "R11 fmode repeat", int'(dec_fmode), 2);

    // R8: robust requested on structured connection acts fast
    cfg_robust = 1'b1; cfg_structured = 1'b1;
    send(1'b1, 3'd6, 2'd0);
    expect_dec(1'b1, 3'd2, "R8 structured fast");
    cfg_robust = 1'b0; cfg_structured = 1'b0;

    // R9: sequence off overrides robust, then tracking restarts
    cfg_sn_off = 1'b1; cfg_robust = 1'b1;
    send(1'b1, 3'd5, 2'd2);
    expect_dec(1'b1, 3'd0, "R9 sn_off accept");
    cfg_sn_off = 1'b0; cfg_robust = 1'b0;
    send(1'b1, 3'd3, 2'd0);
    expect_dec(1'b0, 3'd0, "R9 restart hunt");
    send(1'b1, 3'd4, 2'd0);
    expect_dec(1'b1, 3'd0, "R4 relock");

    // R13: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_zero("R13 mid reset");
    rst_n = 1'b1;
    send(1'b0, 3'd5, 2'd0);
    expect_dec(1'b0, 3'd0, "R13 hunt after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule